// File: doc/BRIEF.md
# Streaming Dual-Parity Byte Generator

This block produces two redundancy bytes for every byte position of a six-way striped page while that page is being written out. It works alongside an eight-chip flash arrangement split into two groups of four: three data chips plus one parity chip per group. The first pass covers data chips 1 to 3 and the second pass covers data chips 4 to 6. The parity chip of the first group receives the plain XOR parity (P). The parity chip of the second group receives the weighted parity (Q), a sum in GF(2^8).

The bytes for a pass arrive as three parallel inputs, together with a byte index and a pass select. A one-cycle strobe marks each byte slot; it is meant to be derived from the falling edge of the flash write strobe. After the first pass, two on-chip byte memories hold the partial P and Q for each index until the second pass reaches that index. The output byte appears two clocks after the strobe, well within the five-clock slot budget. Parity therefore adds no time to the page transfer.

In the first pass, the output is the final P last stored at that index, so P lags one page behind the data it protects. In the second pass, the output is the final Q of the current page. The number of byte indices is set by a parameter, as 2 to the power IDX_W. A full 8 KiB page needs IDX_W = 13.

Top module: `raid6_pq_stream`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `par_vld` is 0 and `par_byte` is 8'h00.
- R2: A strobe sampled high at clock edge N makes `par_vld` high after edge N+2 for exactly one cycle. With no strobe at edge N, `par_vld` is low after edge N+2.
- R3: `par_byte` changes only in cycles where `par_vld` is high.
- R4: For a strobe with `pass_sel`=1, the output is Q. Q is the GF(2^8) sum, using polynomial 0x11D, of 2^(k-1) times the byte of data chip k. Chips 1, 2 and 3 are `din_a`, `din_b` and `din_c` of the `pass_sel`=0 strobe at that index. Chips 4, 5 and 6 are `din_a`, `din_b` and `din_c` of this strobe.
- R5: For a strobe with `pass_sel`=0, the output is the XOR of all six data bytes. These come from the most recent pair of passes that completed at that byte index.
- R6: The stored partial values at one index are unaffected by strobes at any other index, including index 0 and the last index 2^IDX_W-1.
- R7: Strobes on consecutive clocks produce correct results, including a second-pass strobe that immediately follows the first-pass strobe at the same index.
- R8: Data, index and pass-select values presented while the strobe is low have no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_stb | input | 1 | One-cycle pulse per byte slot |
| pass_sel | input | 1 | 0 = chips 1-3 pass, 1 = chips 4-6 pass |
| byte_idx | input | IDX_W | Byte position within the page |
| din_a | input | 8 | Byte of chip 1 (pass 0) or chip 4 (pass 1) |
| din_b | input | 8 | Byte of chip 2 (pass 0) or chip 5 (pass 1) |
| din_c | input | 8 | Byte of chip 3 (pass 0) or chip 6 (pass 1) |
| par_byte | output | 8 | P (pass 0) or Q (pass 1) toward the parity chip |
| par_vld | output | 1 | Marks the cycle in which `par_byte` is new |

## Verification
The bench drives bytes with the top bit set, and all-ones patterns, through every weight. A multiplier that mishandles the reduction polynomial or the shift count would produce a wrong Q on exactly those bytes. It places a second-pass strobe on the clock right after the first pass at the same index. Without forwarding between the memory write and the memory read, that Q would be built from a stale partial. It exercises both ends of the index range and interleaves indices. Address aliasing or an off-by-one in the memory would then surface as a wrong P one page later. Finally, it toggles data and indices with the strobe low, which exposes any write that is not gated by the strobe.

// File: rtl/raid6_pq_stream.sv
module raid6_pq_stream #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_stb,
  input  logic             pass_sel,
  input  logic [IDX_W-1:0] byte_idx,
  input  logic [7:0]       din_a,
  input  logic [7:0]       din_b,
  input  logic [7:0]       din_c,
  output logic [7:0]       par_byte,
  output logic             par_vld
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [7:0] POLY_LO = 8'h1D;

  function automatic logic [7:0] gf_pow2_mul(input logic [7:0] b, input int n);
    logic [7:0] r;
    r = b;
    for (int i = 0; i < 6; i++)
      if (i < n) r = {r[6:0], 1'b0} ^ (r[7] ? POLY_LO : 8'h00);
    return r;
  endfunction

  logic [7:0]       mem_p [DEPTH];
  logic [7:0]       mem_q [DEPTH];
  logic             s1_v, s1_ph;
  logic [IDX_W-1:0] s1_idx;
  logic [7:0]       s1_a, s1_b, s1_c, rd_p, rd_q;
  logic [7:0]       x_sum, q_lo, q_hi, p_new, q_new;
  logic             fwd;

  assign x_sum = s1_a ^ s1_b ^ s1_c;
  assign q_lo  = s1_a ^ gf_pow2_mul(s1_b, 1) ^ gf_pow2_mul(s1_c, 2);
  assign q_hi  = gf_pow2_mul(s1_a, 3) ^ gf_pow2_mul(s1_b, 4) ^ gf_pow2_mul(s1_c, 5);
  assign p_new = s1_ph ? (rd_p ^ x_sum) : x_sum;
  assign q_new = s1_ph ? (rd_q ^ q_hi) : q_lo;
  assign fwd   = s1_v && (s1_idx == byte_idx);

  always_ff @(posedge clk) begin
    if (s1_v) begin
      mem_p[s1_idx] <= p_new;
      mem_q[s1_idx] <= q_new;
    end
    if (byte_stb) begin
      s1_ph  <= pass_sel;
      s1_idx <= byte_idx;
      s1_a   <= din_a;
      s1_b   <= din_b;
      s1_c   <= din_c;
      rd_p   <= fwd ? p_new : mem_p[byte_idx];
      rd_q   <= fwd ? q_new : mem_q[byte_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      par_vld  <= 1'b0;
      par_byte <= 8'h00;
    end else begin
      s1_v    <= byte_stb;
      par_vld <= s1_v;
      if (s1_v) par_byte <= s1_ph ? q_new : rd_p;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!par_vld && par_byte == 8'h00));

  // R2
  vld_follows_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(byte_stb, 2) && $past(rst_n, 1) && $past(rst_n, 2)) |-> par_vld);

  // R2
  no_spurious_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_vld |-> $past(byte_stb, 2));

  // R3
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !par_vld |-> $stable(par_byte));
endmodule

// File: tb/raid6_pq_stream_tb.sv
module raid6_pq_stream_tb;
  localparam int IDX_W = 11;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 0, rst_n = 0, byte_stb = 0, pass_sel = 0;
  logic [IDX_W-1:0] byte_idx = '0;
  logic [7:0] din_a = 0, din_b = 0, din_c = 0, par_byte;
  logic par_vld;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  raid6_pq_stream #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .pass_sel(pass_sel),
    .byte_idx(byte_idx), .din_a(din_a), .din_b(din_b), .din_c(din_c),
    .par_byte(par_byte), .par_vld(par_vld));

  // behavioural reference: page state per index, two-stage expectation line
  int ref_p[int], ref_q[int], full_p[int];
  bit s1_v = 0, s1_known = 0, e_vld = 0, e_known = 1;
  int s1_byte = 0, e_byte = 0;
  string s1_tag = "", e_tag = "R1";

  function automatic int gmul2(int b);
    int r = (b << 1) & 255;
    if (b & 128) r = r ^ 8'h1D;
    return r;
  endfunction

  function automatic int gpow(int b, int n);
    int r = b;
    for (int i = 0; i < n; i++) r = gmul2(r);
    return r;
  endfunction

  task automatic compare();
    checks++;
    if (par_vld !== e_vld) begin
      errors++;
      $display("FAIL %s vld actual %0b expected %0b", e_tag, par_vld, e_vld);
    end
    if (e_known) begin
      checks++;
      if (par_byte !== e_byte[7:0]) begin
        errors++;
        $display("FAIL %s byte actual %02h expected %02h", e_tag, par_byte, e_byte[7:0]);
      end
    end
  endtask

  // one clock: compare, then present new inputs and advance the model
  task automatic cyc(bit s, bit ph, int idx, int a, int b, int c, string tag);
    @(negedge clk);
    compare();
    e_vld = s1_v;
    if (s1_v) begin e_byte = s1_byte; e_known = s1_known; e_tag = s1_tag; end
    else if (e_tag == "R1") e_tag = "R3";
    byte_stb = s; pass_sel = ph; byte_idx = idx[IDX_W-1:0];
    din_a = a[7:0]; din_b = b[7:0]; din_c = c[7:0];
    s1_v = s;
    if (s) begin
      s1_tag = tag;
      if (!ph) begin
        s1_known = full_p.exists(idx);
        s1_byte = s1_known ? full_p[idx] : 0;
        ref_p[idx] = a ^ b ^ c;
        ref_q[idx] = a ^ gpow(b, 1) ^ gpow(c, 2);
      end else begin
        s1_known = 1;
        ref_p[idx] = ref_p[idx] ^ a ^ b ^ c;
        ref_q[idx] = ref_q[idx] ^ gpow(a, 3) ^ gpow(b, 4) ^ gpow(c, 5);
        full_p[idx] = ref_p[idx];
        s1_byte = ref_q[idx];
      end
    end
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++)
      cyc(0, i[0], (i * 37) % DEPTH, i * 11, i * 7 + 3, 255 - i, tag);
  endtask

  initial begin
    repeat (3) begin @(negedge clk); compare(); end   // R1 during reset
    rst_n = 1;
    idle(3, "R1");
    // R4 page 1, indices 0..7 plus last index, gaps between strobes
    for (int i = 0; i < 8; i++) begin cyc(1, 0, i, $urandom & 255, $urandom & 255, $urandom & 255, "R4"); idle(2, "R2"); end
    cyc(1, 0, DEPTH - 1, 8'h80, 8'hFF, 8'hC3, "R6");
    idle(4, "R8");
    for (int i = 0; i < 8; i++) begin cyc(1, 1, i, 8'h80 | i, 8'hFF, 8'h81, "R4"); idle(1, "R3"); end
    cyc(1, 1, DEPTH - 1, 8'hFF, 8'h80, 8'h01, "R6");
    idle(3, "R3");
    // R5 page 2: P from page 1 comes out, interleaved order
    for (int i = 7; i >= 0; i--) cyc(1, 0, i, i * 5, i * 9, 8'hAA, "R5");
    cyc(1, 0, DEPTH - 1, 1, 2, 3, "R6");
    idle(5, "R8");
    for (int i = 0; i < 8; i++) cyc(1, 1, i, 8'hFF, 8'hFE, i, "R4");
    cyc(1, 1, DEPTH - 1, 8'h55, 8'hAA, 8'h80, "R6");
    idle(3, "R2");
    // R7 same index, phase 0 then phase 1 on consecutive clocks
    for (int i = 0; i < 6; i++) begin
      cyc(1, 0, 100 + i, $urandom & 255, 8'h80, $urandom & 255, "R7");
      cyc(1, 1, 100 + i, 8'hFF, $urandom & 255, 8'h80, "R7");
    end
    idle(3, "R8");
    for (int i = 0; i < 6; i++) cyc(1, 0, 100 + i, 0, 0, 0, "R7");
    idle(4, "R5");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule